// File: doc/BRIEF.md
# Idle Retention Entry Timer

This block decides when an idle power domain is allowed to enter its retention state. Each domain has its own 3-bit delay code, an idle flag and a wake flag. All domains share one single-cycle tick pulse that comes from the system timer. While a domain stays idle, the block counts timer ticks for it. When the count reaches the delay its code selects, the block raises that domain's retention request. The request stays high until the domain leaves idle, a wake arrives, or the code is reprogrammed.

The default build has two domains: index 0 is the processor core and index 1 is the SIMD/FP unit. Each domain is fully independent of the other. The code may be rewritten at any moment. A rewrite restarts that domain's count from zero. Code zero turns retention off for that domain.

Top module: `ret_entry_timer`

## Requirements
- R1: After reset every `ret_req_o` bit is low, and a domain needs its full tick count again before it can request.
- R2: With code 3'b000 a domain never raises `ret_req_o`, however many ticks pass while it is idle.
- R3: Codes 3'b001, 3'b010 and 3'b011 raise the request in the cycle after the 2nd, 8th and 32nd tick respectively, and not one tick earlier.
- R4: Codes 3'b100, 3'b101, 3'b110 and 3'b111 raise the request after 64, 128, 256 and 512 ticks respectively, and not one tick earlier.
- R5: Only cycles with `tick_i` high advance the count. Clock cycles without a tick have no effect, and the request can only rise in the cycle after a tick.
- R6: While `idle_i[d]` is low, `ret_req_o[d]` is low in that same cycle and the count of domain d is cleared.
- R7: While `wake_i[d]` is high, `ret_req_o[d]` is low in that same cycle and the count of domain d is cleared.
- R8: A change of `code_i[d]` clears the request in the same cycle. The count restarts from zero, and a tick in the cycle of the change is not counted.
- R9: Once raised, the request stays high as long as idle stays high, wake stays low and the code is unchanged, including over further ticks.
- R10: Domains are independent. `code_i[d]` (bits [3d+2:3d] of the packed vector) together with `idle_i[d]` and `wake_i[d]` affect only `ret_req_o[d]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | NUM_DOMAINS x 3 | Delay code per domain, element d = domain d |
| idle_i | input | NUM_DOMAINS | Domain idle flag |
| tick_i | input | 1 | Single-cycle system timer tick, shared by all domains |
| wake_i | input | NUM_DOMAINS | Domain wake flag |
| ret_req_o | output | NUM_DOMAINS | Retention request per domain |

## Verification
Some rules are checked by assertions on every cycle and for every domain. These are: the request stays low under code zero, under a wake, and outside idle. The request never rises except in the cycle after a tick. And a raised request persists while its conditions hold. The exact tick counts for all seven codes can only be shown by the bench's scenarios, because each needs a long window. The same holds for the restart after a code change or an idle gap, for the point that bare clock cycles do not count, and for the independence of the two domains.

// File: rtl/ret_timer_pkg.sv
package ret_timer_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 10;
    localparam int SHIFT_W = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        cnt_t  cnt;
        logic  req;
        code_t code;
    } chan_state_t;
endpackage

// File: rtl/ret_thresh_decode.sv
module ret_thresh_decode
    import ret_timer_pkg::*;
(
    input  code_t code_i,
    output cnt_t  thresh_o,
    output logic  enable_o
);
    logic [SHIFT_W-1:0] shamt;

    // Codes 1..3 step by factors of four starting at 2; codes 4..7 double from 64.
    always_comb begin
        if (code_i <= code_t'(3)) begin
            shamt = {1'b0, code_i} + {1'b0, code_i} - SHIFT_W'(1);
        end else begin
            shamt = {1'b0, code_i} + SHIFT_W'(2);
        end
        enable_o = |code_i;
        thresh_o = enable_o ? (cnt_t'(1) << shamt) : '0;
    end
endmodule

// File: rtl/ret_channel.sv
module ret_channel
    import ret_timer_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  code_t code_i,
    input  logic  idle_i,
    input  logic  tick_i,
    input  logic  wake_i,
    output logic  req_o
);
    chan_state_t st_d, st_q;
    cnt_t        thresh;
    logic        enable;
    logic        clr;

    ret_thresh_decode u_dec (
        .code_i   (code_i),
        .thresh_o (thresh),
        .enable_o (enable)
    );

    always_comb begin
        st_d      = st_q;
        st_d.code = code_i;
        clr       = !idle_i || wake_i || !enable || (code_i != st_q.code);
        if (clr) begin
            st_d.cnt = '0;
            st_d.req = 1'b0;
        end else begin
            if (tick_i && (st_q.cnt != thresh)) begin
                st_d.cnt = st_q.cnt + cnt_t'(1);
            end
            st_d.req = (st_d.cnt == thresh);
        end
        req_o = st_q.req && !clr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ret_entry_timer.sv
module ret_entry_timer
    import ret_timer_pkg::*;
#(
    parameter int NUM_DOMAINS = 2
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [NUM_DOMAINS-1:0][CODE_W-1:0] code_i,
    input  logic [NUM_DOMAINS-1:0]             idle_i,
    input  logic                               tick_i,
    input  logic [NUM_DOMAINS-1:0]             wake_i,
    output logic [NUM_DOMAINS-1:0]             ret_req_o
);
    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
        ret_channel u_ch (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .code_i (code_i[d]),
            .idle_i (idle_i[d]),
            .tick_i (tick_i),
            .wake_i (wake_i[d]),
            .req_o  (ret_req_o[d])
        );
    end
endmodule

// File: rtl/ret_entry_timer_chk.sv
module ret_entry_timer_chk
    import ret_timer_pkg::*;
#(
    parameter int NUM_DOMAINS = 2
) (
    input logic                               clk_i,
    input logic                               rst_ni,
    input logic [NUM_DOMAINS-1:0][CODE_W-1:0] code_i,
    input logic [NUM_DOMAINS-1:0]             idle_i,
    input logic                               tick_i,
    input logic [NUM_DOMAINS-1:0]             wake_i,
    input logic [NUM_DOMAINS-1:0]             ret_req_o
);
    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_chk
        assert_code0_no_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (code_i[g] == '0) |-> !ret_req_o[g]);

        assert_not_idle_no_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !idle_i[g] |-> !ret_req_o[g]);

        assert_wake_no_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wake_i[g] |-> !ret_req_o[g]);

        assert_rise_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(ret_req_o[g]) |-> $past(tick_i));

        assert_req_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(ret_req_o[g]) && idle_i[g] && !wake_i[g] && $stable(code_i[g]))
            |-> ret_req_o[g]);
    end
endmodule

bind ret_entry_timer ret_entry_timer_chk #(.NUM_DOMAINS(NUM_DOMAINS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code_i),
    .idle_i    (idle_i),
    .tick_i    (tick_i),
    .wake_i    (wake_i),
    .ret_req_o (ret_req_o)
);

// File: tb/ret_entry_timer_tb_top.sv
module ret_entry_timer_tb_top;
    localparam int ND = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ND-1:0][2:0]  code = '0;
    logic [ND-1:0]       idle = '0;
    logic                tick = 1'b0;
    logic [ND-1:0]       wake = '0;
    logic [ND-1:0]       req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ret_entry_timer #(.NUM_DOMAINS(ND)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .code_i    (code),
        .idle_i    (idle),
        .tick_i    (tick),
        .wake_i    (wake),
        .ret_req_o (req)
    );

    function automatic int expected_ticks(input logic [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 8;
            3'd3: return 32;
            3'd4: return 64;
            3'd5: return 128;
            3'd6: return 256;
            3'd7: return 512;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: req actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive for one clock edge, then sample just after it.
    task automatic step(input logic t);
        tick = t;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic t_reset();
        #1;
        check("R1 in reset d0", req[0], 1'b0);
        check("R1 in reset d1", req[1], 1'b0);
        rst_n = 1'b1;
        step(1'b0);
        check("R1 after reset d0", req[0], 1'b0);
        check("R1 after reset d1", req[1], 1'b0);
    endtask

    task automatic t_threshold(input logic [2:0] c);
        int n = expected_ticks(c);
        string tag = (c <= 3'd3) ? "R3" : "R4";
        wake = '0;
        idle = 2'b01;
        code[0] = c;
        step(1'b0);
        for (int i = 0; i < n - 1; i++) step(1'b1);
        check($sformatf("%s code %0d one tick short", tag, c), req[0], 1'b0);
        step(1'b1);
        check($sformatf("%s code %0d at %0d ticks", tag, c, n), req[0], 1'b1);
        step(1'b1);
        step(1'b0);
        check($sformatf("R9 code %0d holds", c), req[0], 1'b1);
        wake[0] = 1'b1;
        #1;
        check("R7 wake drops request", req[0], 1'b0);
        step(1'b1);
        wake[0] = 1'b0;
        step(1'b1);
        check("R7 count cleared by wake", req[0], (n == 2) ? 1'b0 : 1'b0);
        idle = '0;
        step(1'b0);
    endtask

    task automatic t_code_zero();
        idle = 2'b01;
        code[0] = 3'd0;
        step(1'b0);
        for (int i = 0; i < 600; i++) step(1'b1);
        check("R2 code zero never requests", req[0], 1'b0);
        idle = '0;
        step(1'b0);
    endtask

    task automatic t_clock_not_tick();
        idle = 2'b01;
        code[0] = 3'd1;
        step(1'b0);
        for (int i = 0; i < 50; i++) step(1'b0);
        check("R5 bare clocks do not count", req[0], 1'b0);
        step(1'b1);
        for (int i = 0; i < 20; i++) step(1'b0);
        check("R5 one tick is not enough", req[0], 1'b0);
        step(1'b1);
        check("R5 second tick completes", req[0], 1'b1);
        idle = '0;
        step(1'b0);
    endtask

    task automatic t_idle_gap();
        idle = 2'b01;
        code[0] = 3'd1;
        step(1'b0);
        step(1'b1);
        step(1'b1);
        check("R6 precondition", req[0], 1'b1);
        idle[0] = 1'b0;
        #1;
        check("R6 idle low drops request", req[0], 1'b0);
        step(1'b1);
        idle[0] = 1'b1;
        step(1'b1);
        check("R6 count restarted after idle gap", req[0], 1'b0);
        step(1'b1);
        check("R6 counts again after gap", req[0], 1'b1);
        idle = '0;
        step(1'b0);
    endtask

    task automatic t_code_change();
        idle = 2'b01;
        code[0] = 3'd2;
        step(1'b0);
        for (int i = 0; i < 5; i++) step(1'b1);
        code[0] = 3'd1;
        step(1'b1);
        step(1'b1);
        check("R8 tick during change not counted", req[0], 1'b0);
        step(1'b1);
        check("R8 new code counts from zero", req[0], 1'b1);
        code[0] = 3'd3;
        #1;
        check("R8 change drops request", req[0], 1'b0);
        step(1'b0);
        code[0] = 3'd1;
        step(1'b0);
        step(1'b1);
        step(1'b1);
        check("R8 precondition", req[0], 1'b1);
        code[0] = 3'd0;
        #1;
        check("R8 change to zero drops request", req[0], 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1);
        check("R2 stays low after change to zero", req[0], 1'b0);
        idle = '0;
        step(1'b0);
    endtask

    task automatic t_independent();
        wake = '0;
        code[0] = 3'd1;
        code[1] = 3'd3;
        idle = 2'b11;
        step(1'b0);
        step(1'b1);
        step(1'b1);
        check("R10 domain0 at 2 ticks", req[0], 1'b1);
        check("R10 domain1 not yet", req[1], 1'b0);
        for (int i = 0; i < 30; i++) step(1'b1);
        check("R10 domain1 at 32 ticks", req[1], 1'b1);
        check("R10 domain0 still held", req[0], 1'b1);
        wake[1] = 1'b1;
        #1;
        check("R10 wake on d1 drops d1", req[1], 1'b0);
        check("R10 wake on d1 leaves d0", req[0], 1'b1);
        step(1'b0);
        wake = '0;
        idle = '0;
        step(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        summary();
    end

    initial begin
        t_reset();
        t_code_zero();
        for (int c = 1; c < 8; c++) t_threshold(3'(c));
        t_clock_not_tick();
        t_idle_gap();
        t_code_change();
        t_independent();
        summary();
    end
endmodule